// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Engine

This block moves received frames from a byte stream into memory buffers that software describes with a linked list of 32-byte descriptors. Once software arms the queue, the engine fetches the current descriptor and checks that it owns it. It then stores the frame bytes little-endian into that descriptor's buffer. It writes the stored byte count and a status word back into the descriptor and clears ownership, which hands the descriptor back to software. Finally it follows the next pointer. A descriptor flagged as last ends the chain and raises a sticky end-of-queue bit. A descriptor that the engine does not own stops the engine without any write.

Software sees a small register window: a control word, the queue pointer low and high words, an extended status word and a dropped-frame counter. The engine accepts frames whenever it is not armed and discards them, counting each one. A frame already in progress when the queue is armed is discarded whole, so a buffer never starts in the middle of a frame.

States: IDLE (discarding, waiting to be armed between frames), FETCH (four descriptor word reads), FILL (taking bytes and packing them into a word), FLUSH (one buffer word write), PUTLEN (count write-back), PUTSTAT (status write-back). Transitions: IDLE->FETCH when armed and no frame is in progress. FETCH->FILL on an owned descriptor and FETCH->IDLE on an unowned one. FILL->FLUSH when a word fills or the frame ends with bytes pending. FILL->PUTLEN on a last byte with nothing pending. FLUSH->FILL, or FLUSH->PUTLEN after the last byte. PUTLEN->PUTSTAT. PUTSTAT->FETCH on a chained descriptor and PUTSTAT->IDLE on the last one.

Top module: `rxdma_ring`

## Requirements
- R1: After reset every register reads zero (config index 0 control, 1 pointer low, 2 pointer high, 3 extended status, 4 drop count) and no memory request is made.
- R2: The engine touches memory only while control bit 15 (go), control bit 0 (queue enable) and pointer-high bit 31 (valid) are all set. Pointer-high bit 31 reads back as written until the engine clears it.
- R3: A fetch reads exactly the descriptor words at byte offsets 0 (buffer address), 8 (next low), 12 (next high) and 20 (config/status). Bit 15 of config/status marks software-to-engine ownership and bits 31:16 give the buffer size.
- R4: Frame byte n is stored at buffer address + n, in byte lane n mod 4 of a 32-bit word. Byte enables cover only the stored bytes.
- R5: The stored byte count is written to the word at offset 16, with bits 31:16 zero.
- R6: The status word written to offset 20 keeps the buffer size in bits 31:16, clears bit 15 and sets bit 0 (end of frame) and bit 1 (start of frame).
- R7: An end-of-frame CRC error sets bit 12, an overrun flag sets bit 9, and either one sets bit 8 (bad frame).
- R8: Bit 4 (short) is set when an untruncated frame stores fewer than MIN_FRAME bytes.
- R9: Bytes beyond the buffer size are discarded, the count equals the size, and bit 11 (maximum length) is set.
- R10: After a descriptor that is not last, the engine loads the next-low word into the pointer-low register and fetches from there.
- R11: Write-back of a descriptor whose next-high bit 31 is set makes extended-status bit 0 set and clears pointer valid. The bit stays set until software writes 1 to it, and rewriting the pointer with valid re-arms the queue.
- R12: A fetched descriptor without ownership causes no write, clears pointer valid and leaves extended-status bit 0 clear.
- R13: Frames taken while not armed, including one already begun when arming occurs, are discarded. Each such frame adds one to a drop counter that saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access done |
| rx_valid | input | 1 | Frame byte present |
| rx_ready | output | 1 | Byte accepted at next edge when valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is last of frame |
| rx_crc_err | input | 1 | CRC error, sampled with last byte |
| rx_ovr_err | input | 1 | Overrun, sampled with last byte |

## Verification
A wrong state shows at the memory port or at the register window within one descriptor. A lane or address slip corrupts buffer bytes that the bench compares against an arithmetic pattern. A wrong count, truncation or status decision shows in the two written-back words as soon as the write-back finishes. A wrong ownership, chaining or arming decision shows as an extra or missing access, a wrong pointer-low read-back, or an end-of-queue bit that never rises within a few hundred cycles.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    localparam int SIZE_W   = 16;
    localparam int OWN_BIT  = 15;
    localparam int LAST_BIT = 31;
    localparam int VALID_BIT = 31;
    localparam int GO_BIT   = 15;

    typedef enum logic [2:0] {
        RX_IDLE, RX_FETCH, RX_FILL, RX_FLUSH, RX_PUTLEN, RX_PUTSTAT
    } rx_state_e;
endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
    import rxdma_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              step_pulse,
    input  logic [31:0]       step_ptr,
    input  logic              stop_pulse,
    input  logic              eoq_pulse,
    input  logic [DROP_W-1:0] drop_cnt,
    output logic              armed,
    output logic [31:0]       ring_ptr
);
    logic q_go, q_en, q_valid, q_eoq;
    logic wr_ctl, wr_lo, wr_hi, wr_st;

    assign wr_ctl = cfg_we && cfg_addr == 3'd0;
    assign wr_lo  = cfg_we && cfg_addr == 3'd1;
    assign wr_hi  = cfg_we && cfg_addr == 3'd2;
    assign wr_st  = cfg_we && cfg_addr == 3'd3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_go     <= 1'b0;
            q_en     <= 1'b0;
            q_valid  <= 1'b0;
            q_eoq    <= 1'b0;
            ring_ptr <= '0;
        end else begin
            if (wr_ctl) begin
                q_go <= cfg_wdata[GO_BIT];
                q_en <= cfg_wdata[0];
            end
            if (wr_lo)           ring_ptr <= cfg_wdata;
            else if (step_pulse) ring_ptr <= step_ptr;
            if (wr_hi)           q_valid <= cfg_wdata[VALID_BIT];
            else if (stop_pulse) q_valid <= 1'b0;
            if (eoq_pulse)                  q_eoq <= 1'b1;
            else if (wr_st && cfg_wdata[0]) q_eoq <= 1'b0;
        end
    end

    assign armed = q_go && q_en && q_valid;

    always_comb begin
        unique case (cfg_addr)
            3'd0:    cfg_rdata = {16'h0, q_go, 14'h0, q_en};
            3'd1:    cfg_rdata = ring_ptr;
            3'd2:    cfg_rdata = {q_valid, 31'h0};
            3'd3:    cfg_rdata = {31'h0, q_eoq};
            3'd4:    cfg_rdata = 32'(drop_cnt);
            default: cfg_rdata = '0;
        endcase
    end

    p_eoq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eoq_pulse |=> q_eoq);
    p_eoq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_eoq && !(wr_st && cfg_wdata[0])) |=> q_eoq);
    p_stop_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse && !wr_hi) |=> !q_valid);
endmodule

// File: rtl/rxdma_dropctr.sv
module rxdma_dropctr #(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [DROP_W-1:0] cnt
);
    localparam logic [DROP_W-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (inc && cnt != CMAX) cnt <= cnt + 1'b1;
    end

    p_drop_sat_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX) |=> (cnt == CMAX));
    p_drop_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int MIN_FRAME = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        armed,
    input  logic [31:0] ring_ptr,
    output logic        step_pulse,
    output logic [31:0] step_ptr,
    output logic        stop_pulse,
    output logic        eoq_pulse,
    output logic        drop_pulse,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_crc_err,
    input  logic        rx_ovr_err
);
    rx_state_e st, st_nx;
    logic [1:0]        widx;
    logic [31:0]       desc, buf_base, nxt_lo, waddr, wbuf;
    logic              last_d, trunc, crc_f, ovr_f, got_last, mid;
    logic [SIZE_W-1:0] cap, bcnt;
    logic [3:0]        wbe;
    logic [2:0]        fetch_off;
    logic              idle_open, take, room, flush_now, short_f;
    logic [1:0]        lane;
    logic [15:0]       stat16;

    assign idle_open = !(armed && !mid);
    assign rx_ready  = (st == RX_IDLE && idle_open) || st == RX_FILL;
    assign take      = rx_valid && rx_ready;
    assign room      = bcnt < cap;
    assign lane      = bcnt[1:0];
    assign flush_now = room ? (lane == 2'd3 || rx_last) : (rx_last && wbe != 4'b0);
    assign short_f   = !trunc && (bcnt < SIZE_W'(MIN_FRAME));
    assign stat16    = {3'b000, crc_f, trunc, 1'b0, ovr_f, crc_f | ovr_f,
                        3'b000, short_f, 2'b00, 2'b11};

    always_comb begin
        unique case (widx)
            2'd0:    fetch_off = 3'd0;
            2'd1:    fetch_off = 3'd2;
            2'd2:    fetch_off = 3'd3;
            default: fetch_off = 3'd5;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:    if (armed && !mid) st_nx = RX_FETCH;
            RX_FETCH:   if (mem_ack && widx == 2'd3)
                            st_nx = mem_rdata[OWN_BIT] ? RX_FILL : RX_IDLE;
            RX_FILL:    if (take) st_nx = flush_now ? RX_FLUSH :
                                          (rx_last ? RX_PUTLEN : RX_FILL);
            RX_FLUSH:   if (mem_ack) st_nx = got_last ? RX_PUTLEN : RX_FILL;
            RX_PUTLEN:  if (mem_ack) st_nx = RX_PUTSTAT;
            RX_PUTSTAT: if (mem_ack) st_nx = last_d ? RX_IDLE : RX_FETCH;
            default:    st_nx = RX_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx <= '0; desc <= '0; buf_base <= '0; nxt_lo <= '0;
            last_d <= 1'b0; cap <= '0; bcnt <= '0; wbe <= '0;
            wbuf <= '0; waddr <= '0; trunc <= 1'b0; crc_f <= 1'b0;
            ovr_f <= 1'b0; got_last <= 1'b0; mid <= 1'b0;
        end else begin
            if (take) mid <= !rx_last;
            unique case (st)
                RX_IDLE: if (st_nx == RX_FETCH) begin
                    desc <= ring_ptr;
                    widx <= '0;
                end
                RX_FETCH: if (mem_ack) begin
                    widx <= widx + 1'b1;
                    unique case (widx)
                        2'd0: buf_base <= mem_rdata;
                        2'd1: nxt_lo   <= mem_rdata;
                        2'd2: last_d   <= mem_rdata[LAST_BIT];
                        default: begin
                            cap      <= mem_rdata[31:16];
                            bcnt     <= '0;
                            wbe      <= '0;
                            wbuf     <= '0;
                            trunc    <= 1'b0;
                            crc_f    <= 1'b0;
                            ovr_f    <= 1'b0;
                            got_last <= 1'b0;
                        end
                    endcase
                end
                RX_FILL: if (take) begin
                    if (room) begin
                        wbuf[lane*8 +: 8] <= rx_data;
                        wbe[lane]         <= 1'b1;
                        waddr             <= buf_base + 32'({bcnt[SIZE_W-1:2], 2'b00});
                        bcnt              <= bcnt + 1'b1;
                    end else begin
                        trunc <= 1'b1;
                    end
                    if (rx_last) begin
                        got_last <= 1'b1;
                        crc_f    <= rx_crc_err;
                        ovr_f    <= rx_ovr_err;
                    end
                end
                RX_FLUSH: if (mem_ack) begin
                    wbe  <= '0;
                    wbuf <= '0;
                end
                RX_PUTSTAT: if (mem_ack && !last_d) begin
                    desc <= nxt_lo;
                    widx <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_be     = '0;
        mem_wdata  = '0;
        step_pulse = 1'b0;
        stop_pulse = 1'b0;
        eoq_pulse  = 1'b0;
        drop_pulse = 1'b0;
        step_ptr   = nxt_lo;
        unique case (st)
            RX_IDLE: drop_pulse = take && rx_last;
            RX_FETCH: begin
                mem_req    = 1'b1;
                mem_addr   = desc + {27'h0, fetch_off, 2'b00};
                mem_be     = 4'hF;
                stop_pulse = mem_ack && widx == 2'd3 && !mem_rdata[OWN_BIT];
            end
            RX_FLUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = waddr;
                mem_be    = wbe;
                mem_wdata = wbuf;
            end
            RX_PUTLEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc + 32'd16;
                mem_be    = 4'hF;
                mem_wdata = 32'(bcnt);
            end
            RX_PUTSTAT: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = desc + 32'd20;
                mem_be     = 4'hF;
                mem_wdata  = {cap, stat16};
                eoq_pulse  = mem_ack && last_d;
                stop_pulse = mem_ack && last_d;
                step_pulse = mem_ack && !last_d;
            end
            default: ;
        endcase
    end

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    p_be_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != 4'b0));
    p_cap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= cap);
    p_no_mem_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE && !armed) |=> (st == RX_IDLE));
    p_ready_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rx_ready);
endmodule

// File: rtl/rxdma_ring.sv
module rxdma_ring #(
    parameter int MIN_FRAME = 64,
    parameter int DROP_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_crc_err,
    input  logic        rx_ovr_err
);
    logic              armed, step_pulse, stop_pulse, eoq_pulse, drop_pulse;
    logic [31:0]       ring_ptr, step_ptr;
    logic [DROP_W-1:0] drop_cnt;

    rxdma_regs #(.DROP_W(DROP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .step_pulse(step_pulse),
        .step_ptr(step_ptr), .stop_pulse(stop_pulse), .eoq_pulse(eoq_pulse),
        .drop_cnt(drop_cnt), .armed(armed), .ring_ptr(ring_ptr)
    );

    rxdma_dropctr #(.DROP_W(DROP_W)) u_drop (
        .clk(clk), .rst_n(rst_n), .inc(drop_pulse), .cnt(drop_cnt)
    );

    rxdma_engine #(.MIN_FRAME(MIN_FRAME)) u_eng (
        .clk(clk), .rst_n(rst_n), .armed(armed), .ring_ptr(ring_ptr),
        .step_pulse(step_pulse), .step_ptr(step_ptr), .stop_pulse(stop_pulse),
        .eoq_pulse(eoq_pulse), .drop_pulse(drop_pulse), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_last(rx_last), .rx_crc_err(rx_crc_err), .rx_ovr_err(rx_ovr_err)
    );
endmodule

// File: tb/test_rxdma_ring.sv
`timescale 1ns/1ps
module test_rxdma_ring;
    localparam int MINF = 6;
    localparam int DW   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata;
    logic        mem_ack;
    logic        rx_valid = 1'b0, rx_last = 1'b0, rx_crc_err = 1'b0, rx_ovr_err = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;

    logic [31:0] mem [256];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_idx = '0;
    logic [31:0] tb_wd = '0;
    int          rd_n, wr_n;
    int          n_chk = 0, n_bad = 0;
    int          exp_drop = 0;

    always #10 clk = ~clk;

    rxdma_ring #(.MIN_FRAME(MINF), .DROP_W(DW)) i_rxdma_ring (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_last(rx_last), .rx_crc_err(rx_crc_err), .rx_ovr_err(rx_ovr_err)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            rd_n      <= 0;
            wr_n      <= 0;
        end else begin
            if (tb_we) mem[tb_idx] <= tb_wd;
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                    wr_n <= wr_n + 1;
                end else begin
                    rd_n <= rd_n + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wmem(input int byte_addr, input logic [31:0] v);
        @(negedge clk);
        tb_idx = 8'(byte_addr >> 2);
        tb_wd  = v;
        tb_we  = 1'b1;
        @(negedge clk);
        tb_we  = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    function automatic logic [7:0] pat(input int key, input int i);
        return 8'((key * 29 + i * 7 + 1) & 255);
    endfunction

    function automatic logic [7:0] getb(input int a);
        logic [31:0] w;
        w = mem[8'(a >> 2)];
        return w[8*(a & 3) +: 8];
    endfunction

    task automatic send_byte(input logic [7:0] d, input bit last, input bit crc, input bit ovr);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_last = last;
        rx_crc_err = crc & last; rx_ovr_err = ovr & last;
        while (!rx_ready) @(negedge clk);
        @(posedge clk);
        #1 rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic send_frame(input int len, input int key, input bit crc, input bit ovr);
        for (int i = 0; i < len; i++) send_byte(pat(key, i), i == len - 1, crc, ovr);
    endtask

    task automatic set_desc(input int d, input int bufa, input int nxt, input bit last,
                            input int size, input bit own);
        wmem(d + 0, 32'(bufa));
        wmem(d + 4, 32'h0);
        wmem(d + 8, 32'(nxt));
        wmem(d + 12, {last, 31'h0});
        wmem(d + 16, 32'h0);
        wmem(d + 20, {16'(size), own, 15'h0});
    endtask

    task automatic clr_buf(input int bufa, input int words);
        for (int i = 0; i < words; i++) wmem(bufa + 4 * i, 32'h0);
    endtask

    task automatic wait_eoq();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(3'd3, v);
            if (v[0]) break;
        end
    endtask

    task automatic check_frame(input int d, input int bufa, input int size, input int len,
                               input int key, input bit crc, input bit ovr);
        int stored, bad;
        bit trunc, shrt;
        logic [31:0] es;
        logic [7:0] eb;
        stored = (len < size) ? len : size;
        trunc  = len > size;
        shrt   = !trunc && stored < MINF;
        bad = 0;
        for (int i = 0; i < size + 4; i++) begin
            eb = (i < stored) ? pat(key, i) : 8'h00;
            if (getb(bufa + i) !== eb) bad++;
        end
        chk(bad == 0, trunc ? "R9 buffer bytes" : "R4 buffer bytes", bad, 0);
        chk(mem[8'((d + 16) >> 2)] === 32'(stored), "R5 byte count",
            mem[8'((d + 16) >> 2)], stored);
        es = {16'(size), 16'h0003};
        if (shrt)      es |= 32'h0010;
        if (crc | ovr) es |= 32'h0100;
        if (ovr)       es |= 32'h0200;
        if (trunc)     es |= 32'h0800;
        if (crc)       es |= 32'h1000;
        chk(mem[8'((d + 20) >> 2)] === es,
            trunc ? "R9 status" : (shrt ? "R8 status" : ((crc | ovr) ? "R7 status" : "R6 status")),
            mem[8'((d + 20) >> 2)], es);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int r0, w0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 32'h0, "R1 register reset", v, 0);
        end
        chk(mem_req == 1'b0, "R1 no request", mem_req, 0);

        // R13 disarmed frame dropped
        send_frame(4, 1, 0, 0); exp_drop++;
        rd(3'd4, v);
        chk(v == 32'(exp_drop), "R13 drop while disarmed", v, exp_drop);
        chk(rd_n + wr_n == 0, "R13 no access while disarmed", rd_n + wr_n, 0);

        // R2: pointer valid without control enable
        set_desc(32'h40, 32'h100, 0, 1, 16, 0);
        wr(3'd1, 32'h40);
        wr(3'd2, 32'h8000_0000);
        repeat (20) @(negedge clk);
        chk(rd_n + wr_n == 0, "R2 idle until enabled", rd_n + wr_n, 0);
        rd(3'd2, v);
        chk(v == 32'h8000_0000, "R2 valid readback", v, 32'h8000_0000);
        wr(3'd0, 32'h0000_0001);
        repeat (10) @(negedge clk);
        chk(rd_n == 0, "R2 queue enable alone", rd_n, 0);
        wr(3'd0, 32'h0000_8001);

        // R12 unowned descriptor
        repeat (30) @(negedge clk);
        chk(rd_n == 4, "R3 four descriptor reads", rd_n, 4);
        chk(wr_n == 0, "R12 no write on unowned", wr_n, 0);
        rd(3'd2, v);
        chk(v[31] == 1'b0, "R12 valid cleared", v[31], 0);
        rd(3'd3, v);
        chk(v[0] == 1'b0, "R12 no end-of-queue", v[0], 0);
        send_frame(5, 2, 0, 0); exp_drop++;
        rd(3'd4, v);
        chk(v == 32'(exp_drop), "R12 frame dropped when stopped", v, exp_drop);

        // R12 recovery: own it and re-arm
        clr_buf(32'h100, 8);
        set_desc(32'h40, 32'h100, 0, 1, 16, 1);
        wr(3'd2, 32'h8000_0000);
        send_frame(9, 3, 0, 0);
        wait_eoq();
        check_frame(32'h40, 32'h100, 16, 9, 3, 0, 0);

        // Sweep of lengths, alignments, errors, short and truncation
        for (int len = 1; len <= 20; len++) begin
            bit c, o;
            c = (len % 4 == 1) || (len % 4 == 3);
            o = (len % 4 == 2) || (len % 4 == 3);
            wr(3'd3, 32'h1);
            rd(3'd3, v);
            chk(v[0] == 1'b0, "R11 write-one clears end-of-queue", v[0], 0);
            clr_buf(32'h100, 8);
            set_desc(32'h00, 32'h100, 0, 1, 16, 1);
            wr(3'd1, 32'h0);
            wr(3'd2, 32'h8000_0000);
            send_frame(len, 10 + len, c, o);
            wait_eoq();
            rd(3'd3, v);
            chk(v[0] == 1'b1, "R11 end-of-queue set", v[0], 1);
            rd(3'd2, v);
            chk(v[31] == 1'b0, "R11 valid cleared at last", v[31], 0);
            check_frame(32'h00, 32'h100, 16, len, 10 + len, c, o);
        end
        rd(3'd3, v);
        chk(v[0] == 1'b1, "R11 end-of-queue sticky", v[0], 1);
        wr(3'd3, 32'h0);
        rd(3'd3, v);
        chk(v[0] == 1'b1, "R11 write-zero keeps bit", v[0], 1);
        wr(3'd3, 32'h1);

        // R10 chained descriptors
        clr_buf(32'h100, 8);
        clr_buf(32'h140, 4);
        set_desc(32'h00, 32'h100, 32'h20, 0, 16, 1);
        set_desc(32'h20, 32'h140, 0, 1, 8, 1);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h8000_0000);
        send_frame(5, 50, 0, 0);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (mem[5][15] == 1'b0) break;
        end
        repeat (20) @(negedge clk);
        rd(3'd1, v);
        chk(v == 32'h20, "R10 pointer follows next", v, 32'h20);
        rd(3'd3, v);
        chk(v[0] == 1'b0, "R10 no end-of-queue mid-chain", v[0], 0);
        send_frame(10, 51, 0, 1);
        wait_eoq();
        check_frame(32'h00, 32'h100, 16, 5, 50, 0, 0);
        check_frame(32'h20, 32'h140, 8, 10, 51, 0, 1);
        wr(3'd3, 32'h1);

        // R13 frame in progress at arming is dropped whole
        clr_buf(32'h100, 8);
        set_desc(32'h00, 32'h100, 0, 1, 16, 1);
        for (int i = 0; i < 3; i++) send_byte(pat(60, i), 0, 0, 0);
        r0 = rd_n; w0 = wr_n;
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h8000_0000);
        repeat (10) @(negedge clk);
        chk(rd_n == r0 && wr_n == w0, "R13 waits for frame end", rd_n - r0, 0);
        for (int i = 3; i < 6; i++) send_byte(pat(60, i), i == 5, 0, 0);
        exp_drop++;
        rd(3'd4, v);
        chk(v == 32'(exp_drop), "R13 partial frame dropped", v, exp_drop);
        send_frame(7, 61, 1, 0);
        wait_eoq();
        check_frame(32'h00, 32'h100, 16, 7, 61, 1, 0);
        wr(3'd3, 32'h1);

        // R13 saturation of drop counter
        for (int k = 0; k < 7; k++) begin
            send_frame(2, 70 + k, 0, 0);
            exp_drop++;
            rd(3'd4, v);
            chk(v == 32'((exp_drop > 7) ? 7 : exp_drop), "R13 drop count saturates", v,
                (exp_drop > 7) ? 7 : exp_drop);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule